// File: doc/BRIEF.md
# Flag-Escaping Message Framer

The framer sits between a message source and the transmit FIFO of a debug communication port. A frame is a run of payload beats on a valid/ready input stream, closed by a beat that carries a last marker. The framer places an opening flag in front of the frame and a closing flag after it. Any payload byte whose upper three bits are `101` falls in the reserved flag range. Such a byte would be read as a control code by the far end, so it is sent as an escape code followed by the same byte with its top bit flipped. Every other byte passes unchanged.

The opening flag is chosen per frame by a select input sampled on the frame's first beat: a plain message start, or an identification reply. A beat can be marked as carrying no byte. This lets a source close a frame with no payload, so an empty frame is just the opening flag and the closing flag. The output is a registered valid/ready byte stream that runs at one byte per cycle.

Top module: `flag_framer`

## Requirements
- R1: While reset is asserted and in the cycle after it, `out_valid` and `in_ready` are low.
- R2: Each frame's first output byte is 0xAC when `in_sel` is 0 on the frame's first beat, and 0xA1 when it is 1. The value of `in_sel` on later beats of the same frame has no effect on the output.
- R3: Payload bytes outside 0xA0..0xBF appear on the output unchanged and in input order.
- R4: A payload byte in 0xA0..0xBF, that is bits [7:5] equal to 101, is sent as 0xAE followed by the byte with bit 7 inverted.
- R5: After the last payload byte of a frame (its escape pair included), the framer emits 0xAD, which closes the frame.
- R6: When a frame's first beat has `in_void`=1 and `in_last`=1, the frame is exactly the opening flag followed by 0xAD.
- R7: In the cycle after a colliding byte is accepted, `in_ready` is low, so the second escape byte is emitted before more input is taken.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R9: With `out_ready` held high and input presented without gaps, a frame of N bytes containing K colliding bytes is emitted as 2+N+K back-to-back output beats. This is at most 2N+2 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Framer accepts the input beat |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Beat closes the frame |
| in_void | input | 1 | Beat carries no payload byte |
| in_sel | input | 1 | Opening flag select (0: message start, 1: identification reply) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream FIFO accepts the byte |
| out_data | output | 8 | Encoded byte stream |

## Verification
The bench aims at the edges of the flag range: 0x9F, 0xA0, 0xBF and 0xC0. A design that used the wrong range would either escape harmless bytes or let a bare 0xA5 through, and the far end would mistake that byte for a control code. The bench also places colliding bytes first and last in a frame. An escape state that lost the last marker would then drop the closing flag or swallow the next frame's opening flag. Empty frames and `in_sel` toggling in mid-frame check that the opening flag comes only from the first beat. A cycle count on a gapless frame catches a framer that leaves a dead beat around the escape pair. Random downstream stalls catch a byte that changes or vanishes while it waits.

// File: rtl/framer_pkg.sv
package framer_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t CODE_MSG_OPEN = 8'hAC;
    localparam byte_t CODE_ID_OPEN  = 8'hA1;
    localparam byte_t CODE_CLOSE    = 8'hAD;
    localparam byte_t CODE_ESCAPE   = 8'hAE;

    localparam logic [2:0] FLAG_TOP = 3'b101;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BODY,
        ST_ALT,
        ST_TAIL
    } fr_state_e;

    typedef struct packed {
        logic  load;
        byte_t value;
    } out_req_t;

    function automatic logic in_flag_range(input byte_t b);
        return b[BYTE_W-1 -: 3] == FLAG_TOP;
    endfunction

    function automatic byte_t flip_top(input byte_t b);
        return b ^ byte_t'(1 << (BYTE_W-1));
    endfunction

    function automatic byte_t open_code(input logic sel);
        return sel ? CODE_ID_OPEN : CODE_MSG_OPEN;
    endfunction

endpackage

// File: rtl/framer_classify.sv
module framer_classify
    import framer_pkg::*;
(
    input  byte_t data,
    input  logic  void_beat,
    output logic  collide,
    output byte_t alt
);
    always_comb begin
        collide = !void_beat && in_flag_range(data);
        alt     = flip_top(data);
    end
endmodule

// File: rtl/framer_ctrl.sv
module framer_ctrl
    import framer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_ok,
    input  logic     in_valid,
    input  logic     in_last,
    input  logic     in_void,
    input  logic     in_sel,
    input  byte_t    in_data,
    input  logic     collide,
    input  byte_t    alt,
    output logic     in_ready,
    output out_req_t req
);
    fr_state_e st_q, st_d;
    byte_t     alt_q, alt_d;
    logic      last_q, last_d;

    always_comb begin
        st_d      = st_q;
        alt_d     = alt_q;
        last_d    = last_q;
        in_ready  = 1'b0;
        req.load  = 1'b0;
        req.value = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (in_valid && load_ok) begin
                    req.load  = 1'b1;
                    req.value = open_code(in_sel);
                    st_d      = ST_BODY;
                end
            end
            ST_BODY: begin
                in_ready = load_ok;
                if (in_valid && load_ok) begin
                    if (in_void) begin
                        if (in_last) begin
                            req.load  = 1'b1;
                            req.value = CODE_CLOSE;
                            st_d      = ST_IDLE;
                        end
                    end else if (collide) begin
                        req.load  = 1'b1;
                        req.value = CODE_ESCAPE;
                        alt_d     = alt;
                        last_d    = in_last;
                        st_d      = ST_ALT;
                    end else begin
                        req.load  = 1'b1;
                        req.value = in_data;
                        st_d      = in_last ? ST_TAIL : ST_BODY;
                    end
                end
            end
            ST_ALT: begin
                if (load_ok) begin
                    req.load  = 1'b1;
                    req.value = alt_q;
                    st_d      = last_q ? ST_TAIL : ST_BODY;
                end
            end
            ST_TAIL: begin
                if (load_ok) begin
                    req.load  = 1'b1;
                    req.value = CODE_CLOSE;
                    st_d      = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            alt_q  <= '0;
            last_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            alt_q  <= alt_d;
            last_q <= last_d;
        end
    end
endmodule

// File: rtl/framer_outreg.sv
module framer_outreg
    import framer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  out_req_t req,
    input  logic     out_ready,
    output logic     load_ok,
    output logic     out_valid,
    output byte_t    out_data
);
    assign load_ok = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load_ok) begin
            out_valid <= req.load;
            if (req.load) out_data <= req.value;
        end
    end
endmodule

// File: rtl/flag_framer.sv
module flag_framer
    import framer_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [BYTE_W-1:0]   in_data,
    input  logic                in_last,
    input  logic                in_void,
    input  logic                in_sel,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [BYTE_W-1:0]   out_data
);
    logic     collide;
    byte_t    alt;
    logic     load_ok;
    out_req_t req;

    framer_classify u_class (
        .data      (in_data),
        .void_beat (in_void),
        .collide   (collide),
        .alt       (alt)
    );

    framer_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .load_ok  (load_ok),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_void  (in_void),
        .in_sel   (in_sel),
        .in_data  (in_data),
        .collide  (collide),
        .alt      (alt),
        .in_ready (in_ready),
        .req      (req)
    );

    framer_outreg u_out (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .out_ready (out_ready),
        .load_ok   (load_ok),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/flag_framer_chk.sv
module flag_framer_chk
    import framer_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic [7:0]  in_data,
    input logic        in_void,
    input logic        out_valid,
    input logic        out_ready,
    input logic [7:0]  out_data
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!out_valid && !in_ready));

    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r7_stall_after_collide: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_void && in_data[7:5] == 3'b101) |=> !in_ready);

    a_r4_escape_pair: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_data == CODE_ESCAPE)
            |=> (out_valid && out_data[7:5] == 3'b001));

    a_r3_no_bare_flag: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[7:5] != 3'b101 || out_data == CODE_MSG_OPEN ||
                       out_data == CODE_ID_OPEN || out_data == CODE_CLOSE ||
                       out_data == CODE_ESCAPE));

    a_r9_ready_needs_room: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!out_valid || out_ready));
endmodule

bind flag_framer flag_framer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_void   (in_void),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/flag_framer_test.sv
module flag_framer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       in_void = 1'b0;
    logic       in_sel = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    bit    ready_mode = 1'b0;
    bit    timed_out = 1'b0;
    bit    done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    int    first_cyc = -1;
    int    last_cyc = -1;
    bit    held = 1'b0;
    logic [7:0] held_data = '0;

    always #4 clk = ~clk;

    flag_framer uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_void(in_void), .in_sel(in_sel),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_flag(input logic [7:0] b);
        return b[7:5] == 3'b101;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #1;
        out_ready <= ready_mode ? 1'b1 : ($urandom % 4 != 0);
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (held) check(out_valid && out_data == held_data, "R8", out_data, held_data);
            held = out_valid && !out_ready;
            held_data = out_data;
            if (out_valid && out_ready) begin
                if (first_cyc < 0) first_cyc = cyc;
                last_cyc = cyc;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 (unexpected byte)", out_data, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_data == e, t, out_data, e);
                end
            end
        end
    end

    task automatic expect_byte(input logic [7:0] b, input string t);
        exp_q.push_back(b);
        tag_q.push_back(t);
    endtask

    task automatic drive_beat(input logic [7:0] d, input bit last, input bit vd, input bit sel);
        in_data = d; in_last = last; in_void = vd; in_sel = sel; in_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        if (!vd && is_flag(d)) begin
            @(negedge clk);
            check(!in_ready, "R7", in_ready, 0);
            @(posedge clk);
            #1;
        end
    endtask

    task automatic send_frame(input bit sel, input logic [7:0] pl[$], input bit gaps);
        expect_byte(sel ? 8'hA1 : 8'hAC, "R2");
        if (pl.size() == 0) begin
            expect_byte(8'hAD, "R6");
            drive_beat(8'($urandom), 1'b1, 1'b1, sel);
        end else begin
            foreach (pl[i]) begin
                if (is_flag(pl[i])) begin
                    expect_byte(8'hAE, "R4");
                    expect_byte(pl[i] ^ 8'h80, "R4");
                end else begin
                    expect_byte(pl[i], "R3");
                end
            end
            expect_byte(8'hAD, "R5");
            foreach (pl[i]) begin
                drive_beat(pl[i], i == pl.size() - 1, 1'b0, (i == 0) ? sel : 1'($urandom));
                if (gaps) repeat ($urandom % 3) @(posedge clk);
                if (gaps) #1;
            end
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic run();
        logic [7:0] pl[$];
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        check(!out_valid && !in_ready, "R1", {out_valid, in_ready}, 0);
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !in_ready, "R1", {out_valid, in_ready}, 0);
        @(posedge clk); #1;

        pl = {}; send_frame(1'b0, pl, 1'b0); drain();
        pl = {}; send_frame(1'b1, pl, 1'b0); drain();
        pl = '{8'h9F, 8'hA0, 8'hBF, 8'hC0}; send_frame(1'b1, pl, 1'b0); drain();
        pl = '{8'hAC, 8'h00, 8'hFF, 8'hAD}; send_frame(1'b0, pl, 1'b1); drain();

        ready_mode = 1'b1;
        repeat (2) @(posedge clk); #1;
        first_cyc = -1;
        pl = '{8'h11, 8'hA5, 8'h22, 8'hB0};
        send_frame(1'b0, pl, 1'b0); drain();
        check(last_cyc - first_cyc + 1 == 8, "R9", last_cyc - first_cyc + 1, 8);
        ready_mode = 1'b0;

        for (int f = 0; f < 60; f++) begin
            int n;
            n = $urandom % 13;
            pl = {};
            for (int k = 0; k < n; k++)
                pl.push_back(($urandom % 2) ? (8'hA0 | 8'($urandom % 32)) : 8'($urandom));
            send_frame(1'($urandom), pl, 1'($urandom));
            if ($urandom % 2) begin
                repeat ($urandom % 4) @(posedge clk);
                #1;
            end
        end
        drain();
        check(exp_q.size() == 0, "R5", exp_q.size(), 0);
    endtask

    initial begin
        fork
            begin run(); done = 1'b1; end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule